// File: doc/BRIEF.md
# Two-Rail Power-Gate Control and Status Register

This block is a 64-bit control and status register for two switched supply rails, called VDD and VCS here. Software writes it through one write port whose alias input chooses how the write lands: it can replace the writable bits, clear every bit written as one, or set every bit written as one. A read port always returns the whole register. Bit positions use MSB-0 numbering: bit 0 is `rd_data[63]` and bit 63 is `rd_data[0]`.

Each rail has a 2-bit force command field and a small gate sequencer. A force-on or force-off command moves the sequencer out of its idle code for a programmable number of cycles, and then it returns to idle. While the sequencer runs, it drives a read-only state field and a read-only stage-select field. The sequencer has three states. `S_IDLE` reports code 0x8. `S_RAMP_ON` reports code 0x4. `S_RAMP_OFF` reports code 0x2. Its transitions are start-on (`S_IDLE` to `S_RAMP_ON`), start-off (`S_IDLE` to `S_RAMP_OFF`) and ramp-done (either ramp state back to `S_IDLE` once the delay counter expires).

A command written while the rail is ramping is not lost. The sequencer acts on it on the first cycle it is back in `S_IDLE`.

Top module: `pgate_csr`

## Requirements
- R1: After reset, `rd_data` reads 0x0000_0000_0020_2000. All writable bits are 0, both state fields hold 0x8 and both stage-select fields hold 0.
- R2: A write with `wr_alias` = 0 (replace) loads the writable bits 0..8 from the matching `wr_data` bits. The new value is visible on `rd_data` from the cycle after the write edge.
- R3: A write with `wr_alias` = 1 (clear) clears each writable bit whose `wr_data` bit is 1 and leaves the other writable bits unchanged.
- R4: A write with `wr_alias` = 2 (set) sets each writable bit whose `wr_data` bit is 1. A write with `wr_alias` = 3 changes nothing.
- R5: Bits 9..41 and 58..63 always read 0. The status fields ignore every write alias. These are the VDD state at bits 42..45, the VDD stage select at bits 46..49, the VCS state at bits 50..53 and the VCS stage select at bits 54..57.
- R6: The force fields sit at bits 0..1 for VDD and 2..3 for VCS, with bit 0 or 2 as the field MSB. Their codes are 0 = no operation, 1 = force off, 2 = reserved (no operation) and 3 = force on. A field value of 0 or 2 never starts the sequencer. Rewriting the value last acted on does not restart it. A change to 1 or 3 seen while idle starts it one cycle after the write edge.
- R7: A started rail reports 0x4 (on) or 0x2 (off) for exactly DELAY cycles and then reads 0x8 again.
- R8: On start, the rail's stage select becomes 0xF for force on or 0x0 for force off, and it keeps that value until the next start.
- R9: A new start command written while a rail is ramping is held. The rail reads 0x8 for one cycle after the ramp, then starts the held command.
- R10: The two rails sequence independently, and one write can start both of them on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_alias | input | 2 | Write alias: 0 replace, 1 clear, 2 set, 3 none |
| wr_data | input | 64 | Write data, MSB-0 numbering |
| rd_data | output | 64 | Full register contents |

## Verification
Two things in this block can coincide on one edge:
- a register write and a sequencer transition on the same rail;
- the start of both rails.

The bench provokes the first by writing a force-on into VDD partway through a force-off ramp. It then counts cycles at the read port and expects exactly DELAY off-ramp cycles, one idle cycle, and then DELAY on-ramp cycles with stage select 0xF. It provokes the second with a single write that commands both rails. It then expects both state fields to leave 0x8 on the same cycle and return to it together. Separately, an exhaustive sweep over every 9-bit writable pattern under all four aliases compares the register against a bench model computed with masks.

// File: rtl/pgate_csr_pkg.sv
package pgate_csr_pkg;
    localparam int REG_W  = 64;
    localparam int CTRL_W = 9;
    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        WR_REPLACE = 2'd0,
        WR_CLEAR   = 2'd1,
        WR_SET     = 2'd2,
        WR_NONE    = 2'd3
    } wr_alias_e;

    localparam logic [1:0] FC_NOP = 2'd0;
    localparam logic [1:0] FC_OFF = 2'd1;
    localparam logic [1:0] FC_RSV = 2'd2;
    localparam logic [1:0] FC_ON  = 2'd3;

    localparam logic [CODE_W-1:0] CODE_IDLE     = 4'h8;
    localparam logic [CODE_W-1:0] CODE_RAMP_ON  = 4'h4;
    localparam logic [CODE_W-1:0] CODE_RAMP_OFF = 4'h2;
endpackage

// File: rtl/pgate_csr_wmerge.sv
module pgate_csr_wmerge
    import pgate_csr_pkg::*;
#(
    parameter int W = CTRL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_alias,
    input  logic [W-1:0] wr_bits,
    output logic [W-1:0] ctrl_q
);
    logic [W-1:0] ctrl_d;
    wr_alias_e    alias_sel;

    assign alias_sel = wr_alias_e'(wr_alias);

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            unique case (alias_sel)
                WR_REPLACE: ctrl_d = wr_bits;
                WR_CLEAR:   ctrl_d = ctrl_q & ~wr_bits;
                WR_SET:     ctrl_d = ctrl_q | wr_bits;
                WR_NONE:    ctrl_d = ctrl_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // R3: the clear alias never raises a bit
    a_r3_clear_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_alias == WR_CLEAR) |=> ((ctrl_q & ~$past(ctrl_q)) == '0));
    // R4: the set alias never drops a bit
    a_r4_set_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_alias == WR_SET) |=> (($past(ctrl_q) & ~ctrl_q) == '0));
    // R4: the idle alias leaves the register alone
    a_r4_none_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_alias == WR_NONE) |=> $stable(ctrl_q));
endmodule

// File: rtl/pgate_rail_seq.sv
module pgate_rail_seq
    import pgate_csr_pkg::*;
#(
    parameter int DELAY = 8,
    parameter int SEL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd,
    output logic [CODE_W-1:0] code,
    output logic [SEL_W-1:0]  sel
);
    localparam int CNT_W = $clog2(DELAY + 1);

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_RAMP_ON  = 2'd1,
        S_RAMP_OFF = 2'd2
    } seq_state_e;

    seq_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       served;
    logic             start_on, start_off, cmd_quiet;

    assign start_on  = (cmd == FC_ON)  && (served != FC_ON);
    assign start_off = (cmd == FC_OFF) && (served != FC_OFF);
    assign cmd_quiet = (cmd == FC_NOP) || (cmd == FC_RSV);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (start_on)       state_nx = S_RAMP_ON;
                else if (start_off) state_nx = S_RAMP_OFF;
            end
            S_RAMP_ON, S_RAMP_OFF: begin
                if (cnt == '0) state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            served <= FC_NOP;
            sel    <= '0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && state_nx != S_IDLE) begin
                cnt    <= CNT_W'(DELAY - 1);
                served <= cmd;
                sel    <= start_on ? '1 : '0;
            end else begin
                if (state != S_IDLE && cnt != '0) cnt <= cnt - 1'b1;
                if (cmd_quiet) served <= FC_NOP;
            end
        end
    end

    always_comb begin
        unique case (state)
            S_RAMP_ON:  code = CODE_RAMP_ON;
            S_RAMP_OFF: code = CODE_RAMP_OFF;
            default:    code = CODE_IDLE;
        endcase
    end

    // checker-side run length, independent of the ramp counter
    logic [CNT_W-1:0] run_len;
    always_ff @(posedge clk) begin
        if (!rst_n)               run_len <= '0;
        else if (code != CODE_IDLE) run_len <= run_len + 1'b1;
        else                      run_len <= '0;
    end

    // R7: a ramp never outlasts DELAY cycles
    a_r7_ramp_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (code != CODE_IDLE) |-> (run_len < CNT_W'(DELAY)));
    // R7: after DELAY ramp cycles the code is idle
    a_r7_ramp_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (code != CODE_IDLE && run_len == CNT_W'(DELAY - 1)) |=> (code == CODE_IDLE));
    // R6: leaving idle needs a force-on or force-off command
    a_r6_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code) == CODE_IDLE && code != CODE_IDLE) |->
            ($past(cmd) == FC_ON || $past(cmd) == FC_OFF));
    // R8: stage select follows the ramp direction
    a_r8_sel_on: assert property (@(posedge clk) disable iff (!rst_n)
        (code == CODE_RAMP_ON) |-> (sel == '1));
    a_r8_sel_off: assert property (@(posedge clk) disable iff (!rst_n)
        (code == CODE_RAMP_OFF) |-> (sel == '0));
endmodule

// File: rtl/pgate_csr.sv
module pgate_csr
    import pgate_csr_pkg::*;
#(
    parameter int DELAY = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_alias,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data
);
    localparam int N_RAIL  = 2;
    localparam int SEL_W   = 4;
    localparam int GAP_W   = 42 - CTRL_W;              // reserved bits 9..41
    localparam int TAIL_W  = REG_W - 42 - N_RAIL * (CODE_W + SEL_W); // bits 58..63
    localparam int CTRL_LO = REG_W - CTRL_W;

    logic [CTRL_W-1:0] ctrl_q;
    logic [1:0]        rail_cmd  [N_RAIL];
    logic [CODE_W-1:0] rail_code [N_RAIL];
    logic [SEL_W-1:0]  rail_sel  [N_RAIL];
    logic              unused_low;

    assign unused_low = ^wr_data[CTRL_LO-1:0];

    pgate_csr_wmerge #(.W(CTRL_W)) u_wmerge (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_alias (wr_alias),
        .wr_bits  (wr_data[REG_W-1:CTRL_LO]),
        .ctrl_q   (ctrl_q)
    );

    // rail r owns MSB-0 bits 2r..2r+1 of the control word
    for (genvar r = 0; r < N_RAIL; r++) begin : g_rail
        assign rail_cmd[r] = ctrl_q[CTRL_W-1-2*r -: 2];
        pgate_rail_seq #(.DELAY(DELAY), .SEL_W(SEL_W)) u_seq (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd   (rail_cmd[r]),
            .code  (rail_code[r]),
            .sel   (rail_sel[r])
        );
    end

    assign rd_data = {ctrl_q, {GAP_W{1'b0}},
                      rail_code[0], rail_sel[0],
                      rail_code[1], rail_sel[1],
                      {TAIL_W{1'b0}}};

    // R5: a write never moves the status fields by itself
    a_r5_status_write_blind: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rail_code[0] != CODE_IDLE && rail_code[1] != CODE_IDLE)
            |=> ($past(rd_data[21:6]) == rd_data[21:6]) || $changed(rail_code[0]) || $changed(rail_code[1]));
    // R10: both rails start together when one write commands both from idle
    a_r10_joint_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rail_code[0]) == CODE_IDLE && rail_code[0] == CODE_RAMP_ON &&
         $past(rail_code[1]) == CODE_IDLE && $past(rail_cmd[1]) == FC_ON && $past(rail_cmd[0]) == FC_ON &&
         $past(rail_sel[1]) == '0) |-> (rail_code[1] == CODE_RAMP_ON));
endmodule

// File: tb/pgate_csr_test.sv
module pgate_csr_test;
    localparam int DLY = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_alias = 2'd0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pgate_csr #(.DELAY(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_alias(wr_alias), .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic logic [63:0] status_word(input logic [3:0] vs, input logic [3:0] vsel,
                                                input logic [3:0] cs, input logic [3:0] csel);
        return {42'b0, vs, vsel, cs, csel, 6'b0};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] m, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_alias = m; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [8:0] mctl;
        do_reset();
        // R1 reset image
        check("R1 reset", rd_data, 64'h0000_0000_0020_2000);

        // R2 R3 R4 R5: sweep all writable patterns under every alias
        mctl = '0;
        for (int v = 0; v < 512; v++) begin
            for (int m = 0; m < 4; m++) begin
                logic [8:0] vb;
                vb = 9'(v);
                do_write(2'(m), {vb, vb[6:0], 48'hA5A5_5A5A_C3C3});
                case (m)
                    0: mctl = vb;
                    1: mctl = mctl & ~vb;
                    2: mctl = mctl | vb;
                    default: mctl = mctl;
                endcase
                check(m == 0 ? "R2 replace" : m == 1 ? "R3 clear" : "R4 set/none",
                      {55'b0, rd_data[63:55]}, {55'b0, mctl});
                check("R5 reserved zero", {25'b0, rd_data[54:22], rd_data[5:0]}, 64'b0);
            end
        end

        do_reset();
        // R6 R7 R8: force-on on VDD
        do_write(2'd0, 64'hC000_0000_0000_0000);
        check("R6 no start yet", rd_data, 64'hC000_0000_0020_2000);
        for (int k = 0; k < DLY; k++) begin
            @(negedge clk);
            check("R7 R8 vdd ramp on", rd_data[21:6], status_word(4'h4, 4'hF, 4'h8, 4'h0) >> 6);
        end
        @(negedge clk);
        check("R7 back to idle", rd_data[21:6], status_word(4'h8, 4'hF, 4'h8, 4'h0) >> 6);

        // R6: same value again, reserved code, no-op code: no start
        do_write(2'd0, 64'hC000_0000_0000_0000);
        repeat (3) @(negedge clk);
        check("R6 rewrite same cmd", rd_data[21:6], status_word(4'h8, 4'hF, 4'h8, 4'h0) >> 6);
        do_write(2'd0, 64'h8000_0000_0000_0000);
        repeat (3) @(negedge clk);
        check("R6 reserved code", rd_data[21:6], status_word(4'h8, 4'hF, 4'h8, 4'h0) >> 6);
        do_write(2'd0, 64'h0000_0000_0000_0000);
        repeat (3) @(negedge clk);
        check("R6 nop code", rd_data[21:6], status_word(4'h8, 4'hF, 4'h8, 4'h0) >> 6);

        // R9: force-off, then force-on written mid-ramp
        do_write(2'd0, 64'h4000_0000_0000_0000);
        for (int k = 1; k <= DLY; k++) begin
            @(negedge clk);
            check("R9 off ramp", rd_data[21:6], status_word(4'h2, 4'h0, 4'h8, 4'h0) >> 6);
            if (k == 2) begin
                wr_en = 1'b1; wr_alias = 2'd0; wr_data = 64'hC000_0000_0000_0000;
            end
            if (k == 3) wr_en = 1'b0;
        end
        @(negedge clk);
        check("R9 one idle cycle", rd_data[21:6], status_word(4'h8, 4'h0, 4'h8, 4'h0) >> 6);
        for (int k = 0; k < DLY; k++) begin
            @(negedge clk);
            check("R9 held on ramp", rd_data[21:6], status_word(4'h4, 4'hF, 4'h8, 4'h0) >> 6);
        end
        @(negedge clk);
        check("R9 idle after held", rd_data[21:6], status_word(4'h8, 4'hF, 4'h8, 4'h0) >> 6);

        // R10: one write turns both rails off together
        do_write(2'd0, 64'h5000_0000_0000_0000);
        for (int k = 0; k < DLY; k++) begin
            @(negedge clk);
            check("R10 joint off", rd_data[21:6], status_word(4'h2, 4'h0, 4'h2, 4'h0) >> 6);
        end
        @(negedge clk);
        check("R10 joint idle", rd_data, 64'h5000_0000_0020_2000);

        // R4 alias 3 ignored, R5 status ignores an all-ones replace
        do_write(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R4 alias none", rd_data, 64'h5000_0000_0020_2000);
        do_write(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R5 status write-blind", rd_data, 64'hFF80_0000_0020_2000);
        repeat (DLY + 2) @(negedge clk);
        check("R8 sel after on", rd_data[21:6], status_word(4'h8, 4'hF, 4'h8, 4'hF) >> 6);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule